// File: doc/BRIEF.md
# Banked UART Configuration Register File

This block is the byte-wide configuration register store of a 16550-compatible UART that has an enhanced feature set. A host reaches it through a small bus of address, write strobe, read strobe and byte data. The value in the line control register picks which register answers at the low offsets. A value of 0xBF opens the enhanced feature map. Any other value with bit 7 set opens the divisor map. Every other value gives the plain map. The line control register itself answers at offset 3 in every map.

A separate mode register holds the UART in a disabled state from reset until software writes it to zero. The block drives decoded configuration to the serializer and FIFOs, which live outside it: word format, the 16-bit baud divisor, FIFO enable, DMA mode, FIFO trigger selections, one-cycle FIFO clear pulses and the enhanced-function enable. Register writes take effect on the clock edge that samples them. Reads are combinational from the address while the read strobe is high, and return zero when the strobe is low.

Top module: `uart_cfg_regs`

## Requirements
- R1: After reset the mode register reads 0x07, the line control register reads 0x00, `uartInReset` is 1, `divisor` is 0x0000, and `fifoEn` and `enhEn` are 0.
- R2: Offset 8 is the mode register in every map. Only its low 3 bits are stored, and it reads back as {5'b0, mode}. `uartInReset` is 1 exactly when the stored mode is nonzero.
- R3: Offset 3 is the line control register in every map and reads back all 8 bits. `wordLen` = bits 1:0 (00 gives 5 bits, 11 gives 8 bits), `stopBits` = bit 2, `parityEn` = bit 3, `parityEven` = bit 4.
- R4: When the line control value is 0xBF, offset 2 reads and writes the 8-bit enhanced feature register, and `enhEn` equals its bit 4.
- R5: When line control bit 7 is 1 (0xBF included), offset 0 is the divisor low byte and offset 1 is the divisor high byte. Both can be read back, and `divisor` = {high, low}.
- R6: When line control bit 7 is 0, writes to offsets 0 and 1 leave `divisor` unchanged, and reads there return 0x00.
- R7: When the line control value is not 0xBF, a write to offset 2 goes to the FIFO control register and leaves the enhanced feature register unchanged. A read at offset 2 returns {fifoEn, fifoEn, 6'b000001}.
- R8: In a FIFO control write, bit 0 sets `fifoEn`, bit 3 sets `dmaMode` and bits 7:6 set `rxTrig`. Bit 1 and bit 2 each produce a one-cycle pulse on `rxFifoClr` and `txFifoClr` respectively, in the cycle after the write.
- R9: FIFO control bits 5:4 update `txTrig` only while `enhEn` is 1. Otherwise `txTrig` keeps its value.
- R10: Reads of offsets 4 to 7 and 9 to 15 return 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 4 | Register offset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data (combinational) |
| uartInReset | output | 1 | UART held disabled (mode nonzero) |
| modeOut | output | 3 | Stored mode value |
| wordLen | output | 2 | Data bits select |
| stopBits | output | 1 | Extra stop bit |
| parityEn | output | 1 | Parity enable |
| parityEven | output | 1 | Even parity select |
| divisor | output | 16 | Baud divisor |
| fifoEn | output | 1 | FIFOs enabled |
| dmaMode | output | 1 | DMA mode select |
| rxTrig | output | 2 | Receive FIFO trigger select |
| txTrig | output | 2 | Transmit FIFO trigger select |
| rxFifoClr | output | 1 | Receive FIFO clear pulse |
| txFifoClr | output | 1 | Transmit FIFO clear pulse |
| enhEn | output | 1 | Enhanced functions enabled |

## Verification
The bench moves through the three maps and checks which register answers at offsets 0, 1 and 2 in each one. A decoder that tested only bit 7 would let a FIFO control write in the 0xBF map clobber the enhanced feature register, and the readback at offset 2 would show it. Divisor writes made while bit 7 is clear are checked for having no effect. A decoder that ignored the map would change the divisor there. The clear pulses are sampled in the cycle after the write and again one cycle later, which catches bits that stick high. The transmit trigger field is written with enhanced functions both on and off, which exposes a missing gate on `enhEn`.

// File: rtl/uart_cfg_pkg.sv
package uart_cfg_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int MODE_W = 3;

  localparam logic [ADDR_W-1:0] OFS_DLL  = 4'd0;
  localparam logic [ADDR_W-1:0] OFS_DLH  = 4'd1;
  localparam logic [ADDR_W-1:0] OFS_FIFO = 4'd2;
  localparam logic [ADDR_W-1:0] OFS_LCR  = 4'd3;
  localparam logic [ADDR_W-1:0] OFS_MODE = 4'd8;

  localparam logic [DATA_W-1:0] LCR_ENH_KEY = 8'hBF;
  localparam logic [MODE_W-1:0] MODE_RST    = 3'd7;

  typedef struct packed {
    logic wrMode;
    logic wrLcr;
    logic wrEfr;
    logic wrFcr;
    logic wrDll;
    logic wrDlh;
  } cfgStrobes_t;

  typedef enum logic [2:0] {
    RD_NONE, RD_MODE, RD_LCR, RD_EFR, RD_IIR, RD_DLL, RD_DLH
  } rdSel_t;
endpackage

// File: rtl/uart_cfg_ctrl.sv
module uart_cfg_ctrl
  import uart_cfg_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] lcrVal,
  output cfgStrobes_t       stb,
  output rdSel_t            rdSel
);
  logic enhMap;
  logic divMap;

  assign enhMap = (lcrVal == LCR_ENH_KEY);
  assign divMap = lcrVal[DATA_W-1];

  always_comb begin
    stb = '0;
    if (wrEn) begin
      unique case (addr)
        OFS_MODE: stb.wrMode = 1'b1;
        OFS_LCR:  stb.wrLcr  = 1'b1;
        OFS_FIFO: begin
          stb.wrEfr = enhMap;
          stb.wrFcr = !enhMap;
        end
        OFS_DLL:  stb.wrDll = divMap;
        OFS_DLH:  stb.wrDlh = divMap;
        default:  ;
      endcase
    end
  end

  always_comb begin
    rdSel = RD_NONE;
    if (rdEn) begin
      unique case (addr)
        OFS_MODE: rdSel = RD_MODE;
        OFS_LCR:  rdSel = RD_LCR;
        OFS_FIFO: rdSel = enhMap ? RD_EFR : RD_IIR;
        OFS_DLL:  rdSel = divMap ? RD_DLL : RD_NONE;
        OFS_DLH:  rdSel = divMap ? RD_DLH : RD_NONE;
        default:  rdSel = RD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/uart_cfg_dp.sv
module uart_cfg_dp
  import uart_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  cfgStrobes_t       stb,
  input  rdSel_t            rdSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] lcrQ,
  output logic [MODE_W-1:0] modeQ,
  output logic [DATA_W-1:0] efrQ,
  output logic [2*DATA_W-1:0] divQ,
  output logic              fifoEnQ,
  output logic              dmaQ,
  output logic [1:0]        rxTrigQ,
  output logic [1:0]        txTrigQ,
  output logic              rxClrQ,
  output logic              txClrQ
);
  logic [DATA_W-1:0] dllQ;
  logic [DATA_W-1:0] dlhQ;
  logic              enhOn;

  assign enhOn = efrQ[4];
  assign divQ  = {dlhQ, dllQ};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeQ   <= MODE_RST;
      lcrQ    <= '0;
      efrQ    <= '0;
      dllQ    <= '0;
      dlhQ    <= '0;
      fifoEnQ <= 1'b0;
      dmaQ    <= 1'b0;
      rxTrigQ <= '0;
      txTrigQ <= '0;
      rxClrQ  <= 1'b0;
      txClrQ  <= 1'b0;
    end else begin
      rxClrQ <= stb.wrFcr & wrData[1];
      txClrQ <= stb.wrFcr & wrData[2];
      if (stb.wrMode) modeQ <= wrData[MODE_W-1:0];
      if (stb.wrLcr)  lcrQ  <= wrData;
      if (stb.wrEfr)  efrQ  <= wrData;
      if (stb.wrDll)  dllQ  <= wrData;
      if (stb.wrDlh)  dlhQ  <= wrData;
      if (stb.wrFcr) begin
        fifoEnQ <= wrData[0];
        dmaQ    <= wrData[3];
        rxTrigQ <= wrData[7:6];
        if (enhOn) txTrigQ <= wrData[5:4];
      end
    end
  end

  always_comb begin
    unique case (rdSel)
      RD_MODE: rdData = {{(DATA_W-MODE_W){1'b0}}, modeQ};
      RD_LCR:  rdData = lcrQ;
      RD_EFR:  rdData = efrQ;
      RD_IIR:  rdData = {fifoEnQ, fifoEnQ, 6'b000001};
      RD_DLL:  rdData = dllQ;
      RD_DLH:  rdData = dlhQ;
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/uart_cfg_regs.sv
module uart_cfg_regs
  import uart_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              uartInReset,
  output logic [MODE_W-1:0] modeOut,
  output logic [1:0]        wordLen,
  output logic              stopBits,
  output logic              parityEn,
  output logic              parityEven,
  output logic [2*DATA_W-1:0] divisor,
  output logic              fifoEn,
  output logic              dmaMode,
  output logic [1:0]        rxTrig,
  output logic [1:0]        txTrig,
  output logic              rxFifoClr,
  output logic              txFifoClr,
  output logic              enhEn
);
  cfgStrobes_t       stb;
  rdSel_t            rdSel;
  logic [DATA_W-1:0] lcrVal;
  logic [DATA_W-1:0] efrVal;

  uart_cfg_ctrl u_ctrl (
    .addr   (addr),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .lcrVal (lcrVal),
    .stb    (stb),
    .rdSel  (rdSel)
  );

  uart_cfg_dp u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (stb),
    .rdSel   (rdSel),
    .wrData  (wrData),
    .rdData  (rdData),
    .lcrQ    (lcrVal),
    .modeQ   (modeOut),
    .efrQ    (efrVal),
    .divQ    (divisor),
    .fifoEnQ (fifoEn),
    .dmaQ    (dmaMode),
    .rxTrigQ (rxTrig),
    .txTrigQ (txTrig),
    .rxClrQ  (rxFifoClr),
    .txClrQ  (txFifoClr)
  );

  assign uartInReset = (modeOut != '0);
  assign wordLen     = lcrVal[1:0];
  assign stopBits    = lcrVal[2];
  assign parityEn    = lcrVal[3];
  assign parityEven  = lcrVal[4];
  assign enhEn       = efrVal[4];
endmodule

// File: rtl/uart_cfg_checker.sv
module uart_cfg_checker
  import uart_cfg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic              rdEn,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic [DATA_W-1:0] lcrVal,
  input logic              uartInReset,
  input logic [2*DATA_W-1:0] divisor,
  input logic              enhEn,
  input logic [1:0]        txTrig,
  input logic              rxFifoClr,
  input logic              txFifoClr
);
  assert_rx_clr_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rxFifoClr |-> $past(wrEn && addr == OFS_FIFO && lcrVal != LCR_ENH_KEY && wrData[1]));

  assert_tx_clr_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    txFifoClr |-> $past(wrEn && addr == OFS_FIFO && lcrVal != LCR_ENH_KEY && wrData[2]));

  assert_div_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(lcrVal[DATA_W-1]) |-> $stable(divisor));

  assert_efr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lcrVal != LCR_ENH_KEY) |-> $stable(enhEn));

  assert_mode_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wrEn && addr == OFS_MODE) |-> (uartInReset == ($past(wrData[MODE_W-1:0]) != '0)));

  assert_txtrig_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(enhEn) |-> $stable(txTrig));

  assert_iir_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && addr == OFS_FIFO && lcrVal != LCR_ENH_KEY) |-> (rdData[5:0] == 6'b000001));

  assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && addr > OFS_LCR && addr != OFS_MODE) |-> (rdData == '0));
endmodule

bind uart_cfg_regs uart_cfg_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .addr        (addr),
  .wrEn        (wrEn),
  .rdEn        (rdEn),
  .wrData      (wrData),
  .rdData      (rdData),
  .lcrVal      (lcrVal),
  .uartInReset (uartInReset),
  .divisor     (divisor),
  .enhEn       (enhEn),
  .txTrig      (txTrig),
  .rxFifoClr   (rxFifoClr),
  .txFifoClr   (txFifoClr)
);

// File: tb/uart_cfg_regs_bench.sv
module uart_cfg_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic        uartInReset;
  logic [2:0]  modeOut;
  logic [1:0]  wordLen;
  logic        stopBits, parityEn, parityEven;
  logic [15:0] divisor;
  logic        fifoEn, dmaMode;
  logic [1:0]  rxTrig, txTrig;
  logic        rxFifoClr, txFifoClr, enhEn;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_cfg_regs u_uart_cfg_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .uartInReset(uartInReset),
    .modeOut(modeOut), .wordLen(wordLen), .stopBits(stopBits),
    .parityEn(parityEn), .parityEven(parityEven), .divisor(divisor),
    .fifoEn(fifoEn), .dmaMode(dmaMode), .rxTrig(rxTrig), .txTrig(txTrig),
    .rxFifoClr(rxFifoClr), .txFifoClr(txFifoClr), .enhEn(enhEn)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Drive on a falling edge; returns on the next falling edge, after the
  // sampling rising edge, with registered outputs already updated.
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #1 d = rdData;
    rdEn = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(4'd8, v); check("R1", "mode after reset", v, 8'h07);
    rd(4'd3, v); check("R1", "lcr after reset", v, 8'h00);
    check("R1", "uartInReset", uartInReset, 1);
    check("R1", "divisor", divisor, 0);
    check("R1", "fifoEn", fifoEn, 0);
    check("R1", "enhEn", enhEn, 0);
  endtask

  task automatic t_mode();
    logic [7:0] v;
    wr(4'd8, 8'h00);
    check("R2", "uartInReset after 00", uartInReset, 0);
    rd(4'd8, v); check("R2", "mode readback 00", v, 8'h00);
    wr(4'd8, 8'hFD);
    rd(4'd8, v); check("R2", "mode keeps 3 bits", v, 8'h05);
    check("R2", "uartInReset after 05", uartInReset, 1);
    wr(4'd8, 8'h00);
  endtask

  task automatic t_lcr();
    logic [7:0] v;
    wr(4'd3, 8'h1F);
    rd(4'd3, v); check("R3", "lcr readback", v, 8'h1F);
    check("R3", "wordLen", wordLen, 3);
    check("R3", "stopBits", stopBits, 1);
    check("R3", "parity en/even", {parityEn, parityEven}, 2'b11);
    wr(4'd3, 8'h03);
    check("R3", "8N1 format", {wordLen, stopBits, parityEn, parityEven}, 5'b11000);
  endtask

  task automatic t_div_closed();
    logic [7:0] v;
    wr(4'd0, 8'h55);
    wr(4'd1, 8'h66);
    check("R6", "divisor unchanged", divisor, 16'h0000);
    rd(4'd0, v); check("R6", "offset0 read", v, 8'h00);
    rd(4'd1, v); check("R6", "offset1 read", v, 8'h00);
  endtask

  task automatic t_div_open();
    logic [7:0] v;
    wr(4'd3, 8'h80);
    wr(4'd0, 8'h07);
    wr(4'd1, 8'h12);
    check("R5", "divisor in 0x80 map", divisor, 16'h1207);
    rd(4'd1, v); check("R5", "dlh readback", v, 8'h12);
    rd(4'd3, v); check("R3", "lcr in divisor map", v, 8'h80);
    wr(4'd3, 8'hBF);
    wr(4'd1, 8'h00);
    check("R5", "divisor in 0xBF map", divisor, 16'h0007);
    rd(4'd0, v); check("R5", "dll readback 0xBF map", v, 8'h07);
  endtask

  task automatic t_efr();
    logic [7:0] v;
    rd(4'd2, v); check("R4", "efr reset", v, 8'h00);
    wr(4'd2, 8'hFF);
    rd(4'd2, v); check("R4", "efr readback FF", v, 8'hFF);
    wr(4'd2, 8'h10);
    rd(4'd2, v); check("R4", "efr readback 10", v, 8'h10);
    check("R4", "enhEn", enhEn, 1);
    check("R8", "no clear pulse from efr write", {rxFifoClr, txFifoClr}, 0);
    rd(4'd3, v); check("R3", "lcr in enhanced map", v, 8'hBF);
  endtask

  task automatic t_fcr();
    logic [7:0] v;
    wr(4'd3, 8'h80);
    wr(4'd2, 8'h07);
    check("R8", "clear pulses high", {rxFifoClr, txFifoClr}, 2'b11);
    check("R8", "fifoEn", fifoEn, 1);
    check("R8", "dmaMode", dmaMode, 0);
    @(negedge clk);
    check("R8", "clear pulses one cycle", {rxFifoClr, txFifoClr}, 2'b00);
    rd(4'd2, v); check("R7", "iir with fifos", v, 8'hC1);
    check("R7", "enhEn untouched", enhEn, 1);
    wr(4'd2, 8'hCD);
    check("R8", "only tx clear", {rxFifoClr, txFifoClr}, 2'b01);
    check("R8", "dma/rxTrig", {dmaMode, rxTrig}, 3'b111);
    check("R9", "txTrig with enh", txTrig, 0);
    wr(4'd2, 8'h31);
    check("R9", "txTrig set with enh", txTrig, 3);
    check("R8", "no pulse bits clear", {rxFifoClr, txFifoClr}, 2'b00);
  endtask

  task automatic t_txtrig_gate();
    logic [7:0] v;
    wr(4'd3, 8'hBF);
    wr(4'd2, 8'h00);
    check("R4", "enhEn off", enhEn, 0);
    wr(4'd3, 8'h03);
    wr(4'd2, 8'h00);
    check("R9", "txTrig kept without enh", txTrig, 3);
    check("R8", "fifoEn cleared", fifoEn, 0);
    rd(4'd2, v); check("R7", "iir no fifos", v, 8'h01);
  endtask

  task automatic t_unmapped();
    logic [7:0] v;
    wr(4'd5, 8'hAA);
    wr(4'd12, 8'h77);
    rd(4'd5, v);  check("R10", "offset5 read", v, 8'h00);
    rd(4'd12, v); check("R10", "offset12 read", v, 8'h00);
    rd(4'd3, v);  check("R10", "lcr intact", v, 8'h03);
    rd(4'd8, v);  check("R10", "mode intact", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mode();
    t_lcr();
    t_div_closed();
    t_div_open();
    t_efr();
    t_fcr();
    t_txtrig_gate();
    t_unmapped();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule